// File: doc/BRIEF.md
# Zero-Turnaround Flow-Through Synchronous SRAM

This block is a synchronous static RAM. Its data bus never needs an idle cycle when it turns from reading to writing. Address and control are sampled on a rising clock edge. The data phase of that operation takes place in the cycle that follows. A read drives the stored word flow-through, straight from the array with no output register. A write takes its data from the input bus at the edge that closes the data cycle. Reads and writes can therefore follow one another on every clock.

Words are 36 bits wide and split into four 9-bit lanes, each with its own active-low write enable. Three chip-enable pins decode the select. A clock-enable pin freezes the whole pipeline. A load/advance pin either starts a new operation or continues the previous one at the next address within a four-word wrap. Write data passes through a one-entry buffer before it reaches the array. A read from that address in the next data cycle is served by merging the buffer contents into the array word. The tri-state data bus is modelled as separate input, output and output-enable ports. The default depth is 128 words, which keeps simulation small.

Top module: `ztsram_flow`

## Requirements
- R1: The device is selected only when `ce1_n`=0, `ce2_n`=0 and `ce2`=1. Any other combination, sampled on a load edge, starts no operation. A write attempted under such a combination leaves memory unchanged.
- R2: On an edge with `cen_n`=0, `adv`=0 and the chip selected, the block captures `addr`, `rw` (1 = read, 0 = write) and `bw_n` as a new operation.
- R3: A read loaded at edge k puts the word at the captured address on `dq_out` during the cycle after edge k. It asserts `dq_oe` in that cycle when `oe_n`=0.
- R4: `dq_oe` is 1 only during a read data cycle in which `oe_n` is 0.
- R5: A write loaded at edge k stores `dq_in` as sampled at edge k+1, at the captured address. Only lanes whose `bw_n` bit is 0 are stored. Lane j covers bits 9j+8 down to 9j.
- R6: An edge that samples a load without select makes `dq_oe` 0 in the following cycle.
- R7: From reset until the first read data cycle, `dq_oe` is 0.
- R8: An edge with `cen_n`=1 changes no state. A pending read keeps driving the same word. A pending write captures its data only at a later edge with `cen_n`=0.
- R9: On an edge with `cen_n`=0 and `adv`=1, the previous operation type is kept. The address advances by one in its two low bits, wrapping within an aligned group of four, and `bw_n` is sampled again. After a deselect, an advance stays deselected. The chip-enable pins are ignored on advance edges.
- R10: A read whose data cycle directly follows the data cycle of a write to the same address returns the merged new data. Lanes that were not written keep their old value.
- R11: A write data cycle never drives the bus, whatever `oe_n` is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset of pipeline state |
| cen_n | input | 1 | Clock enable, active low |
| ce1_n | input | 1 | Chip enable, active low |
| ce2_n | input | 1 | Second chip enable, active low |
| ce2 | input | 1 | Third chip enable, active high |
| adv | input | 1 | 1 = advance the previous operation, 0 = load a new one |
| rw | input | 1 | 1 = read, 0 = write |
| bw_n | input | 4 | Lane write enables, active low |
| addr | input | 7 | Word address |
| oe_n | input | 1 | Output enable, active low, applies in the current cycle |
| dq_in | input | 36 | Data bus, incoming side |
| dq_out | output | 36 | Data bus, outgoing side |
| dq_oe | output | 1 | Bus drive enable |

## Verification
A wrong pipeline state shows at the ports one cycle later: `dq_oe` is wrong, or the data of a flow-through read is wrong in the cycle after the faulty edge. A write committed to the wrong address or lane, or dropped while the clock is disabled, stays hidden until that word is read. For this reason every written word is read back later. Some reads are placed straight after a write to the same address, so a forwarding fault shows up in the very next data cycle.

// File: rtl/ztsram_pkg.sv
package ztsram_pkg;

  typedef enum logic [1:0] {
    OP_NONE  = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2
  } op_e;

  // three-pin select: two active-low enables and one active-high enable
  function automatic logic chip_sel(input logic e1_n, input logic e2_n, input logic e3);
    return !e1_n && !e2_n && e3;
  endfunction

endpackage

// File: rtl/ztsram_ctrl.sv
module ztsram_ctrl
  import ztsram_pkg::*;
#(
  parameter int ADDR_W = 7,
  parameter int LANES  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cen_n,
  input  logic              ce1_n,
  input  logic              ce2_n,
  input  logic              ce2,
  input  logic              adv,
  input  logic              rw,
  input  logic [LANES-1:0]  bw_n,
  input  logic [ADDR_W-1:0] addr,
  output op_e               ph_op,
  output logic [ADDR_W-1:0] ph_addr,
  output logic [LANES-1:0]  ph_bw_n,
  output logic              load_sel,
  output logic              load_desel,
  output logic              burst_step
);

  localparam int BURST_W = 2;

  function automatic logic [ADDR_W-1:0] burst_next(input logic [ADDR_W-1:0] a);
    logic [ADDR_W-1:0] r;
    r = a;
    r[BURST_W-1:0] = a[BURST_W-1:0] + 1'b1;
    return r;
  endfunction

  logic sel;
  assign sel        = chip_sel(ce1_n, ce2_n, ce2);
  assign load_sel   = !cen_n && !adv && sel;
  assign load_desel = !cen_n && !adv && !sel;
  assign burst_step = !cen_n && adv && (ph_op != OP_NONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_op   <= OP_NONE;
      ph_addr <= '0;
      ph_bw_n <= '1;
    end else if (load_sel) begin
      ph_op   <= rw ? OP_READ : OP_WRITE;
      ph_addr <= addr;
      ph_bw_n <= bw_n;
    end else if (load_desel) begin
      ph_op   <= OP_NONE;
    end else if (burst_step) begin
      ph_addr <= burst_next(ph_addr);
      ph_bw_n <= bw_n;
    end
  end

  assert_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    load_sel |=> (ph_addr == $past(addr)) && (ph_op == ($past(rw) ? OP_READ : OP_WRITE)));

  assert_desel_R6: assert property (@(posedge clk) disable iff (!rst_n)
    load_desel |=> ph_op == OP_NONE);

  assert_cen_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cen_n |=> $stable(ph_op) && $stable(ph_addr) && $stable(ph_bw_n));

  assert_burst_wrap_R9: assert property (@(posedge clk) disable iff (!rst_n)
    burst_step |=> (ph_addr[BURST_W-1:0] == $past(ph_addr[BURST_W-1:0]) + 2'd1)
                && (ph_addr[ADDR_W-1:BURST_W] == $past(ph_addr[ADDR_W-1:BURST_W]))
                && (ph_op == $past(ph_op)));

endmodule

// File: rtl/ztsram_array.sv
module ztsram_array
  import ztsram_pkg::*;
#(
  parameter int ADDR_W = 7,
  parameter int LANES  = 4,
  parameter int LANE_W = 9
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cen_n,
  input  op_e                      ph_op,
  input  logic [ADDR_W-1:0]        ph_addr,
  input  logic [LANES-1:0]         ph_bw_n,
  input  logic [LANES*LANE_W-1:0]  dq_in,
  output logic [LANES*LANE_W-1:0]  rd_word,
  output logic                     fwd_hit
);

  localparam int DATA_W = LANES * LANE_W;
  localparam int DEPTH  = 1 << ADDR_W;

  function automatic logic [DATA_W-1:0] lane_merge(input logic [DATA_W-1:0] base,
                                                   input logic [DATA_W-1:0] upd,
                                                   input logic [LANES-1:0]  en_n);
    logic [DATA_W-1:0] r;
    r = base;
    for (int k = 0; k < LANES; k++)
      if (!en_n[k]) r[k*LANE_W +: LANE_W] = upd[k*LANE_W +: LANE_W];
    return r;
  endfunction

  logic [DATA_W-1:0] mem [DEPTH];
  logic              wb_valid;
  logic [ADDR_W-1:0] wb_addr;
  logic [DATA_W-1:0] wb_data;
  logic [LANES-1:0]  wb_bw_n;
  logic              capture;
  logic              commit;

  assign capture = !cen_n && (ph_op == OP_WRITE);
  assign commit  = !cen_n && wb_valid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wb_valid <= 1'b0;
      wb_addr  <= '0;
      wb_data  <= '0;
      wb_bw_n  <= '1;
    end else if (!cen_n) begin
      wb_valid <= capture;
      if (capture) begin
        wb_addr <= ph_addr;
        wb_data <= dq_in;
        wb_bw_n <= ph_bw_n;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (commit) mem[wb_addr] <= lane_merge(mem[wb_addr], wb_data, wb_bw_n);
  end

  assign fwd_hit = wb_valid && (wb_addr == ph_addr);
  assign rd_word = fwd_hit ? lane_merge(mem[ph_addr], wb_data, wb_bw_n) : mem[ph_addr];

  assert_capture_R5: assert property (@(posedge clk) disable iff (!rst_n)
    capture |=> wb_valid && (wb_data == $past(dq_in)) && (wb_addr == $past(ph_addr)));

  assert_wb_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cen_n |=> $stable(wb_valid) && $stable(wb_data) && $stable(wb_addr));

endmodule

// File: rtl/ztsram_flow.sv
module ztsram_flow
  import ztsram_pkg::*;
#(
  parameter int ADDR_W = 7,
  parameter int LANES  = 4,
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cen_n,
  input  logic                    ce1_n,
  input  logic                    ce2_n,
  input  logic                    ce2,
  input  logic                    adv,
  input  logic                    rw,
  input  logic [LANES-1:0]        bw_n,
  input  logic [ADDR_W-1:0]       addr,
  input  logic                    oe_n,
  input  logic [LANES*LANE_W-1:0] dq_in,
  output logic [LANES*LANE_W-1:0] dq_out,
  output logic                    dq_oe
);

  localparam int DATA_W = LANES * LANE_W;

  op_e               ph_op;
  logic [ADDR_W-1:0] ph_addr;
  logic [LANES-1:0]  ph_bw_n;
  logic              load_sel;
  logic              load_desel;
  logic              burst_step;
  logic [DATA_W-1:0] rd_word;
  logic              fwd_hit;

  ztsram_ctrl #(.ADDR_W(ADDR_W), .LANES(LANES)) ctrl_i (
    .clk(clk), .rst_n(rst_n), .cen_n(cen_n),
    .ce1_n(ce1_n), .ce2_n(ce2_n), .ce2(ce2),
    .adv(adv), .rw(rw), .bw_n(bw_n), .addr(addr),
    .ph_op(ph_op), .ph_addr(ph_addr), .ph_bw_n(ph_bw_n),
    .load_sel(load_sel), .load_desel(load_desel), .burst_step(burst_step)
  );

  ztsram_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) array_i (
    .clk(clk), .rst_n(rst_n), .cen_n(cen_n),
    .ph_op(ph_op), .ph_addr(ph_addr), .ph_bw_n(ph_bw_n),
    .dq_in(dq_in), .rd_word(rd_word), .fwd_hit(fwd_hit)
  );

  assign dq_oe  = (ph_op == OP_READ) && !oe_n;
  assign dq_out = (ph_op == OP_READ) ? rd_word : '0;

  // raw pin decode, kept separate from the controller's own decode
  logic pin_sel;
  assign pin_sel = chip_sel(ce1_n, ce2_n, ce2);

  assert_oe_gate_R4: assert property (@(posedge clk) disable iff (!rst_n)
    dq_oe |-> !oe_n);

  assert_write_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!cen_n && !adv && pin_sel && !rw) |=> !dq_oe);

  assert_reset_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rst_n) |-> !dq_oe);

  assert_desel_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!cen_n && !adv && !pin_sel) |=> !dq_oe);

endmodule

// File: tb/ztsram_flow_tb_top.sv
module ztsram_flow_tb_top;
  localparam int AW = 7;
  localparam int DW = 36;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic          rst_n, cen_n, ce1_n, ce2_n, ce2, adv, rw, oe_n;
  logic [3:0]    bw_n;
  logic [AW-1:0] addr;
  logic [DW-1:0] dq_in, dq_out;
  logic          dq_oe;

  ztsram_flow dut_i (
    .clk(clk), .rst_n(rst_n), .cen_n(cen_n), .ce1_n(ce1_n), .ce2_n(ce2_n), .ce2(ce2),
    .adv(adv), .rw(rw), .bw_n(bw_n), .addr(addr), .oe_n(oe_n),
    .dq_in(dq_in), .dq_out(dq_out), .dq_oe(dq_oe)
  );

  int    checks = 0;
  int    fails  = 0;
  bit    done   = 0;
  string tag    = "R7";
  int    wseed  = 0;

  // behavioural reference: array plus one pending operation, writes commit at once
  logic [DW-1:0] m_mem [1<<AW];
  logic          m_valid, m_write;
  logic [AW-1:0] m_addr;
  logic [3:0]    m_bw;

  function automatic logic [DW-1:0] wdata(input logic [AW-1:0] a, input int s);
    return {9'(a*3 + s), 9'(a*5 + s + 1), 9'(a + s*7), 9'(a ^ s)};
  endfunction

  task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp,
                     input string what);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic tick();
    logic exp_oe;
    if (m_valid && m_write && !cen_n) dq_in = wdata(m_addr, wseed);
    else dq_in = {DW{1'b1}} ^ DW'(checks * 7919);
    #1;
    exp_oe = m_valid && !m_write && !oe_n;
    chk(tag, {35'b0, dq_oe}, {35'b0, exp_oe}, "dq_oe");
    if (exp_oe) chk(tag, dq_out, m_mem[m_addr], "dq_out");
    @(posedge clk);
    if (!cen_n) begin
      if (m_valid && m_write)
        for (int k = 0; k < 4; k++)
          if (!m_bw[k]) m_mem[m_addr][k*9 +: 9] = dq_in[k*9 +: 9];
      if (!adv) begin
        if (!ce1_n && !ce2_n && ce2) begin
          m_valid = 1'b1; m_write = !rw; m_addr = addr; m_bw = bw_n;
        end else m_valid = 1'b0;
      end else if (m_valid) begin
        m_addr[1:0] = m_addr[1:0] + 2'd1;
        m_bw = bw_n;
      end
    end
    @(negedge clk);
  endtask

  task automatic ld(input bit rd, input logic [AW-1:0] a, input logic [3:0] bw = 4'h0,
                    input bit oe = 1'b0);
    cen_n = 0; ce1_n = 0; ce2_n = 0; ce2 = 1; adv = 0;
    rw = rd; addr = a; bw_n = bw; oe_n = oe;
    tick();
  endtask

  task automatic desel(input logic [2:0] ce = 3'b101, input bit oe = 1'b0);
    cen_n = 0; {ce1_n, ce2_n, ce2} = ce; adv = 0; rw = 0; addr = 7'd10; bw_n = 4'h0; oe_n = oe;
    tick();
  endtask

  task automatic advance(input logic [3:0] bw = 4'h0, input bit oe = 1'b0);
    cen_n = 0; ce1_n = 1; ce2_n = 1; ce2 = 0; adv = 1; rw = 0; bw_n = bw; oe_n = oe;
    addr = 7'd99;
    tick();
  endtask

  task automatic stall(input bit oe = 1'b0);
    cen_n = 1; ce1_n = 0; ce2_n = 0; ce2 = 1; adv = 0; rw = 0; addr = 7'd3; bw_n = 4'h0;
    oe_n = oe;
    tick();
  endtask

  initial begin
    #1600000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < (1<<AW); i++) m_mem[i] = 'x;
    m_valid = 0; m_write = 0; m_addr = '0; m_bw = '1;
    rst_n = 0; cen_n = 0; ce1_n = 1; ce2_n = 1; ce2 = 0; adv = 0; rw = 1;
    bw_n = '1; addr = '0; oe_n = 0; dq_in = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    #1;
    chk("R7", {35'b0, dq_oe}, 36'd0, "dq_oe in reset");
    rst_n = 1;
    @(negedge clk);

    // R7: idle after reset keeps the bus released
    tag = "R7"; desel(); desel(); desel();

    // R5: fill every word
    tag = "R5"; wseed = 1;
    for (int a = 0; a < (1<<AW); a++) ld(0, 7'(a));
    desel();

    // R3: flow-through back-to-back reads
    tag = "R3";
    for (int a = 0; a < 16; a++) ld(1, 7'(a * 5));
    desel();

    // R2: loads interleaving reads and writes at scattered addresses
    tag = "R2"; wseed = 2;
    for (int i = 0; i < 8; i++) begin
      ld(0, 7'(i * 13 + 1));
      ld(1, 7'(i * 11 + 2));
    end
    desel();

    // R5: partial lane writes, then read back
    tag = "R5"; wseed = 3;
    ld(0, 7'd30, 4'b1110); ld(0, 7'd31, 4'b0101); ld(0, 7'd32, 4'b1111); ld(0, 7'd33, 4'b0111);
    desel();
    ld(1, 7'd30); ld(1, 7'd31); ld(1, 7'd32); ld(1, 7'd33); desel();

    // R10: read straight after a write to the same word (forwarding)
    tag = "R10";
    for (int i = 0; i < 6; i++) begin
      wseed = 20 + i;
      ld(0, 7'(50 + i), (i % 2 == 0) ? 4'b1010 : 4'b0000);
      ld(1, 7'(50 + i));
    end
    ld(0, 7'd60, 4'b0110); ld(0, 7'd61); ld(1, 7'd60); ld(1, 7'd61);
    desel();

    // R11: write data cycles with output enable asserted
    tag = "R11"; wseed = 4;
    ld(0, 7'd70, 4'h0, 0); ld(0, 7'd71, 4'h0, 0); ld(1, 7'd70, 4'h0, 0); ld(0, 7'd72, 4'h0, 0);
    desel(3'b101, 0); ld(1, 7'd72); desel();

    // R4: reads with output enable high
    tag = "R4";
    ld(1, 7'd5, 4'h0, 1); ld(1, 7'd6, 4'h0, 0); ld(1, 7'd7, 4'h0, 1); desel(3'b101, 1);

    // R1 / R6: every non-selecting combination, write attempts must not land
    tag = "R1";
    for (int c = 0; c < 8; c++)
      if (c != 1) begin
        desel(3'(c));
        ld(1, 7'd10);
      end
    tag = "R6";
    ld(1, 7'd11); desel(3'b000); desel(3'b011); ld(1, 7'd10); desel();

    // R8: clock enable high freezes read and write data phases
    tag = "R8"; wseed = 6;
    ld(1, 7'd5); stall(); stall(); stall(1); stall(); desel();
    ld(0, 7'd40); stall(); stall(); desel(); ld(1, 7'd40);
    ld(0, 7'd41, 4'b1100); stall(); ld(1, 7'd41); stall(); desel();

    // R9: advance continues the operation with a wrap inside four words
    tag = "R9"; wseed = 9;
    ld(1, 7'd6); advance(); advance(); advance(); advance(); desel();
    ld(0, 7'd13); advance(4'b0011); advance(); advance(4'b1110); desel();
    ld(1, 7'd12); ld(1, 7'd13); ld(1, 7'd14); ld(1, 7'd15);
    desel(); advance(); advance(); desel();

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule